// File: doc/BRIEF.md
# Four-Lane Seven-to-One Serial Word Deserializer

This block turns four serial data lanes, sent alongside a forwarded clock, back into one 28-bit parallel word per forwarded-clock period. A bit clock running at exactly seven times the forwarded clock, rising together with it, samples every lane. Each lane fills a 7-bit shift register, most significant bit first. On each forwarded-clock rising edge the seven freshly sampled bits of every lane are taken into the slow domain and placed in the output word.

A framing offset lets the user move the word boundary one bit at a time when the link comes up misaligned. The block also sequences bring-up. The external delay line is held in reset until the clock multiplier reports lock. The parallel output stays marked invalid until the delay controller reports calibration done and the capture pipeline has refilled. The analog clock multiplier, the delay line and the differential buffers are outside the block. Only their lock and ready flags and the multiplied clock come in.

Top module: `lvds_lane_deser`

## Requirements
- R1: Lane L supplies output bits [7L+6:7L]. The first bit sampled in a forwarded-clock period lands in bit 7L+6 and the seventh lands in bit 7L.
- R2: With framing offset 0, a word consists of the bits sampled on the seven bit-clock rising edges starting with the one that coincides with a forwarded-clock rising edge.
- R3: A word whose first bit is sampled at forwarded-clock edge m is on `dataOut` after forwarded-clock edge m+2 and holds for one period.
- R4: `delayRst` is 1 out of reset and while the synchronized lock flag is 0. It falls in the third forwarded-clock cycle after `pllLocked` rises, and rises again in the third cycle after lock is lost.
- R5: `wordValid` is 0 out of reset and whenever lock or delay-ready, as seen through the synchronizers in the previous cycle, was 0.
- R6: After `delayReady` rises while the delay line is out of reset, `wordValid` rises in the fifth forwarded-clock cycle: two synchronizer stages, one state step and two fill cycles.
- R7: Each forwarded-clock edge that samples `bitslip` high while `wordValid` is 1 advances the framing offset s by one, modulo 7. The output lane is then bits [s+6:s] of the 14-bit value {previous lane word, current lane word}. The new offset shows on `dataOut` one edge after the edge that took the request.
- R8: `bitslip` has no effect while `wordValid` is 0. Framing after bring-up is offset 0 even if `bitslip` was pulsed during bring-up.
- R9: Loss of lock drops `wordValid` in the third cycle and resets the framing offset to 0 for the next bring-up.
- R10: A transmitted word equal to 1 presents 7'b0000001 on lane 0 (`dataOut[6:0]`) and zero on every other lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fastClk | input | 1 | Bit clock, seven times the forwarded clock, edge-aligned with it |
| slowClk | input | 1 | Forwarded clock (parallel side) |
| rstN | input | 1 | Asynchronous active-low reset |
| pllLocked | input | 1 | Lock flag from the clock multiplier |
| delayReady | input | 1 | Calibration-done flag from the delay controller |
| bitslip | input | 1 | Framing advance request, sampled on slowClk |
| serIn | input | 4 | Serial data, one bit per lane |
| delayRst | output | 1 | Reset for the external delay line |
| wordValid | output | 1 | dataOut holds a recovered word |
| dataOut | output | 28 | Recovered parallel word |

## Verification
The assertions assume the bit clock runs at exactly seven times the forwarded clock and rises on the same instant as every forwarded-clock rising edge. They also assume `bitslip`, `pllLocked` and `delayReady` change away from the forwarded-clock rising edge. The bench produces both clocks from one process, with a forwarded-clock edge on every seventh bit-clock edge. It changes serial data only on bit-clock falling edges and changes the control inputs shortly after forwarded-clock falling edges. As in a real link, it lowers `delayReady` whenever it drops lock.

// File: rtl/lvds_deser_pkg.sv
package lvds_deser_pkg;

  typedef enum logic [1:0] {
    ST_WAIT_LOCK,
    ST_WAIT_CAL,
    ST_FILL,
    ST_RUN
  } deserState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic slipStep;
    logic slipClear;
  } deserCtrl_t;

endpackage

// File: rtl/lvds_deser_sync.sv
module lvds_deser_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/lvds_deser_ctrl.sv
module lvds_deser_ctrl
  import lvds_deser_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILL_CYCLES = 2
) (
  input  logic       slowClk,
  input  logic       rstN,
  input  logic       pllLocked,
  input  logic       delayReady,
  input  logic       bitslipReq,
  output deserCtrl_t ctrl,
  output logic       delayRst,
  output logic       wordValid
);
  localparam int FILL_W = (FILL_CYCLES > 1) ? $clog2(FILL_CYCLES) : 1;

  logic        lockSync;
  logic        readySync;
  deserState_t state;
  logic [FILL_W-1:0] fillCnt;

  lvds_deser_sync #(.STAGES(SYNC_STAGES)) lockSync_i (
    .clk(slowClk), .rstN(rstN), .din(pllLocked), .dout(lockSync)
  );
  lvds_deser_sync #(.STAGES(SYNC_STAGES)) readySync_i (
    .clk(slowClk), .rstN(rstN), .din(delayReady), .dout(readySync)
  );

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_WAIT_LOCK;
      fillCnt <= '0;
    end else if (!lockSync) begin
      state   <= ST_WAIT_LOCK;
    end else begin
      case (state)
        ST_WAIT_LOCK: state <= ST_WAIT_CAL;
        ST_WAIT_CAL: if (readySync) begin
          state   <= ST_FILL;
          fillCnt <= '0;
        end
        ST_FILL: begin
          if (!readySync)                                state  <= ST_WAIT_CAL;
          else if (fillCnt == FILL_W'(FILL_CYCLES - 1)) state  <= ST_RUN;
          else                                           fillCnt <= fillCnt + 1'b1;
        end
        ST_RUN: if (!readySync) state <= ST_WAIT_CAL;
        default: state <= ST_WAIT_LOCK;
      endcase
    end
  end

  assign delayRst       = (state == ST_WAIT_LOCK);
  assign wordValid      = (state == ST_RUN);
  assign ctrl.slipStep  = (state == ST_RUN) && bitslipReq;
  assign ctrl.slipClear = (state != ST_RUN);

  // R4: without synchronized lock the delay line is reset on the next cycle
  a_r4_delay_rst_until_lock: assert property (@(posedge slowClk) disable iff (!rstN)
    !lockSync |=> delayRst);

  // R5: a valid word implies lock and ready were both seen a cycle earlier
  a_r5_valid_needs_flags: assert property (@(posedge slowClk) disable iff (!rstN)
    wordValid |-> ($past(lockSync) && $past(readySync)));

  // R9: losing lock withdraws valid on the following cycle
  a_r9_lock_loss_drops_valid: assert property (@(posedge slowClk) disable iff (!rstN)
    $fell(lockSync) |=> !wordValid);
endmodule

// File: rtl/lvds_deser_dpath.sv
module lvds_deser_dpath
  import lvds_deser_pkg::*;
#(
  parameter int LANES = 4,
  parameter int RATIO = 7
) (
  input  logic                     fastClk,
  input  logic                     slowClk,
  input  logic                     rstN,
  input  logic [LANES-1:0]         serIn,
  input  deserCtrl_t               ctrl,
  output logic [LANES*RATIO-1:0]   dataOut
);
  localparam int WORD_W = LANES * RATIO;
  localparam int SLIP_W = $clog2(RATIO);
  localparam int WIN_W  = 2 * RATIO;

  logic [SLIP_W-1:0] slipOffset;
  logic [WORD_W-1:0] picked;

  // framing offset, advanced one bit per granted request
  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN)                  slipOffset <= '0;
    else if (ctrl.slipClear)    slipOffset <= '0;
    else if (ctrl.slipStep)     slipOffset <= (slipOffset == SLIP_W'(RATIO - 1)) ? '0
                                              : slipOffset + 1'b1;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [RATIO-1:0] shiftReg;
    logic [RATIO-1:0] laneCap;
    logic [RATIO-1:0] prevCap;
    logic [WIN_W-1:0] window;
    logic [WIN_W-1:0] shifted;

    // bit-rate sampling, first bit ends up in the MSB
    always_ff @(posedge fastClk) begin
      shiftReg <= {shiftReg[RATIO-2:0], serIn[g]};
    end

    // edge-aligned transfer: the slow edge sees the seven preceding samples
    always_ff @(posedge slowClk or negedge rstN) begin
      if (!rstN) begin
        laneCap <= '0;
        prevCap <= '0;
      end else begin
        laneCap <= shiftReg;
        prevCap <= laneCap;
      end
    end

    assign window  = {prevCap, laneCap};
    assign shifted = window >> slipOffset;
    assign picked[g*RATIO +: RATIO] = shifted[RATIO-1:0];
  end

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) dataOut <= '0;
    else       dataOut <= picked;
  end

  // R7: offset never leaves the range of bit positions
  a_r7_offset_bound: assert property (@(posedge slowClk) disable iff (!rstN)
    slipOffset <= SLIP_W'(RATIO - 1));

  // R7: each granted request moves framing by exactly one position, wrapping
  a_r7_slip_advance: assert property (@(posedge slowClk) disable iff (!rstN)
    (ctrl.slipStep && !ctrl.slipClear) |=>
      (slipOffset == (($past(slipOffset) == SLIP_W'(RATIO - 1)) ? '0 : $past(slipOffset) + 1'b1)));

  // R8: outside run, framing returns to offset zero
  a_r8_slip_cleared: assert property (@(posedge slowClk) disable iff (!rstN)
    ctrl.slipClear |=> (slipOffset == '0));
endmodule

// File: rtl/lvds_lane_deser.sv
module lvds_lane_deser
  import lvds_deser_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int RATIO       = 7,
  parameter int SYNC_STAGES = 2,
  parameter int FILL_CYCLES = 2
) (
  input  logic                   fastClk,
  input  logic                   slowClk,
  input  logic                   rstN,
  input  logic                   pllLocked,
  input  logic                   delayReady,
  input  logic                   bitslip,
  input  logic [LANES-1:0]       serIn,
  output logic                   delayRst,
  output logic                   wordValid,
  output logic [LANES*RATIO-1:0] dataOut
);
  deserCtrl_t ctrl;

  lvds_deser_ctrl #(.SYNC_STAGES(SYNC_STAGES), .FILL_CYCLES(FILL_CYCLES)) ctrl_i (
    .slowClk(slowClk), .rstN(rstN), .pllLocked(pllLocked), .delayReady(delayReady),
    .bitslipReq(bitslip), .ctrl(ctrl), .delayRst(delayRst), .wordValid(wordValid)
  );

  lvds_deser_dpath #(.LANES(LANES), .RATIO(RATIO)) dpath_i (
    .fastClk(fastClk), .slowClk(slowClk), .rstN(rstN), .serIn(serIn),
    .ctrl(ctrl), .dataOut(dataOut)
  );
endmodule

// File: tb/lvds_lane_deser_tb.sv
`timescale 1ps/1ps
module lvds_lane_deser_tb_top;
  localparam int HALF = 1430;   // bit clock half period; forwarded clock ~50 MHz

  logic fastClk = 0, slowClk = 0, rstN = 0;
  logic pllLocked = 0, delayReady = 0, bitslip = 0;
  logic [3:0] serIn = '0;
  logic delayRst, wordValid;
  logic [27:0] dataOut;

  int checks = 0, fails = 0;
  int ph = 6;
  bit done = 0;
  bit useFixed = 0;
  logic [27:0] fixedWord = '0;
  logic [27:0] txQ[$];
  logic [27:0] lastTx = '0;
  int slipReq = 0, slipSeen = 0;

  lvds_lane_deser dut_i (
    .fastClk(fastClk), .slowClk(slowClk), .rstN(rstN), .pllLocked(pllLocked),
    .delayReady(delayReady), .bitslip(bitslip), .serIn(serIn),
    .delayRst(delayRst), .wordValid(wordValid), .dataOut(dataOut)
  );

  // both clocks from one process: forwarded edge on every seventh bit edge
  initial forever begin
    #HALF;
    ph = (ph == 6) ? 0 : ph + 1;
    slowClk = (ph < 4);
    fastClk = 1;
    #HALF;
    fastClk = 0;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [27:0] expWord(input logic [27:0] prev, input logic [27:0] cur, input int s);
    logic [27:0] e;
    for (int l = 0; l < 4; l++) begin
      logic [13:0] w;
      w = {prev[l*7 +: 7], cur[l*7 +: 7]} >> s;
      e[l*7 +: 7] = w[6:0];
    end
    return e;
  endfunction

  // driver: one word per forwarded period, MSB first, pushed to the scoreboard
  task automatic driveWord(input logic [27:0] w);
    do @(negedge fastClk); while (ph != 6);
    txQ.push_back(w);
    for (int b = 0; b < 7; b++) begin
      if (b != 0) @(negedge fastClk);
      for (int l = 0; l < 4; l++) serIn[l] = w[l*7 + 6 - b];
    end
  endtask

  initial forever driveWord(useFixed ? fixedWord : 28'($urandom));

  // monitor: R1 R2 R3 R7 compare each valid word with the word sent two periods earlier
  always @(negedge slowClk) begin
    int eff;
    logic [27:0] cur;
    eff = slipSeen;
    slipSeen = slipReq;
    while (txQ.size() > 3) lastTx = txQ.pop_front();
    if (txQ.size() == 3) begin
      cur = txQ.pop_front();
      if (wordValid && !done)
        chk(dataOut == expWord(lastTx, cur, eff % 7), "R1/R2/R3/R7 word",
            32'(dataOut), 32'(expWord(lastTx, cur, eff % 7)));
      lastTx = cur;
    end
  end

  task automatic waitSlow(input int n);
    for (int i = 0; i < n; i++) @(negedge slowClk);
  endtask

  task automatic slipPulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge slowClk); #100;
      bitslip = 1;
      if (wordValid) slipReq++;
    end
    @(negedge slowClk); #100;
    bitslip = 0;
  endtask

  task automatic countUntil(input bit wantValid, input int expN, input string req);
    int k = 0;
    do begin @(negedge slowClk); k++; end
    while ((wantValid ? wordValid : !delayRst) == 0 && k < 50);
    chk(k == expN, req, 32'(k), 32'(expN));
  endtask

  task automatic bringUp(input bit slipDuringCal);
    @(negedge slowClk); #100; pllLocked = 1;
    countUntil(0, 3, "R4 delayRst release");
    chk(!wordValid, "R5 no valid before ready", 32'(wordValid), 0);
    waitSlow(3);
    if (slipDuringCal) slipPulse(2);   // R8 ignored while not running
    @(negedge slowClk); #100; delayReady = 1;
    countUntil(1, 5, "R6 valid after ready");
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge slowClk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
  end

  initial begin
    waitSlow(3);
    chk(delayRst == 1, "R4 reset state delayRst", 32'(delayRst), 1);
    chk(wordValid == 0, "R5 reset state valid", 32'(wordValid), 0);
    #100; rstN = 1;
    waitSlow(4);
    chk(delayRst == 1, "R4 held without lock", 32'(delayRst), 1);
    chk(wordValid == 0, "R5 no valid without lock", 32'(wordValid), 0);

    bringUp(1);
    waitSlow(60);                       // random words, offset 0 (R8 after pulses)

    useFixed = 1; fixedWord = 28'd1;    // R10
    waitSlow(5);
    chk(dataOut[6:0] == 7'b0000001, "R10 lane0 word", 32'(dataOut[6:0]), 1);
    chk(dataOut[27:7] == '0, "R10 other lanes", 32'(dataOut[27:7]), 0);
    fixedWord = 28'h8000000;            // R1: first bit of lane 3 lands in bit 27
    waitSlow(5);
    chk(dataOut == 28'h8000000, "R1 lane3 msb first", 32'(dataOut), 32'h8000000);
    useFixed = 0;

    slipPulse(1); waitSlow(12);         // R7 single steps and a double step
    slipPulse(2); waitSlow(12);
    slipPulse(4); waitSlow(12);         // wraps to offset 0
    slipPulse(3); waitSlow(12);         // offset 3 before lock loss

    @(negedge slowClk); #100; pllLocked = 0; delayReady = 0;
    begin
      int k = 0;
      do begin @(negedge slowClk); k++; end while (wordValid && k < 50);
      chk(k == 3, "R9 valid drop on lock loss", 32'(k), 3);
    end
    chk(delayRst == 1, "R9 delay reset on lock loss", 32'(delayRst), 1);
    #100; slipReq = 0; slipSeen = 0;
    waitSlow(4);
    bringUp(0);
    waitSlow(20);                       // R9 framing back at offset 0
    report();
  end
endmodule